// File: doc/BRIEF.md
# Serial Receive Frame Synchronizer

This block sits behind a time-division-multiplexed serial receive pin. Each rising edge of its clock carries one data bit. A separate input pulses once per frame. The block refuses to pass data on until it has seen two frame pulses spaced exactly one programmed frame length apart. After that it packs the serial stream into words and writes them into a downstream FIFO. Every write is a one-cycle strobe that carries a complete word.

The true frame start can trail the pulse by a programmable number of bit clocks. The first captured bit is always a frame-start bit, so the consumer never needs its own timeslot counter. The bit order inside a word is selectable. A pulse that turns up at the wrong place drops lock at once and discards the partial word. A write attempted while the FIFO reports full sets a sticky overflow flag.

Top module: `rxfs_frame_sync`

## Requirements
- R1: During and right after reset, `in_sync` is 0, `fifo_wr` is 0 and `overflow` is 0.
- R2: The bit clock that carries a frame pulse is position 0, and each later bit clock adds 1 up to `cfg_frame_len`-1, then wraps to 0. A pulse is expected when the position wraps to 0. `in_sync` rises in the cycle after a pulse that falls at the expected position of the pulse seen before it. A single pulse never gives sync. Missing pulses while in sync leave `in_sync` at 1.
- R3: No FIFO write happens while `in_sync` is 0, and no bit received before sync is written.
- R4: With `cfg_offset` = 0, the first captured bit is the bit that carries the pulse completing sync. The first write strobe appears 32 bit clocks after that pulse.
- R5: With `cfg_offset` > 0, where `cfg_offset` < `cfg_frame_len` is required, capture starts at position `cfg_offset` after the pulse completing sync. That is the start of the next frame. The first strobe appears `cfg_offset`+32 bit clocks after that pulse.
- R6: Once capture has started, every following bit is captured without a gap, across frame boundaries. Each group of 32 bits gives one `fifo_wr` pulse, one cycle long, in the cycle after the 32nd bit.
- R7: With `cfg_msb_first` = 0, the first captured bit of a word is in `fifo_wdata` bit 0 and the 32nd is in bit 31.
- R8: With `cfg_msb_first` = 1, the first captured bit is in bit 31 and the 32nd is in bit 0.
- R9: A pulse at a non-expected position while in sync clears `in_sync` in the next cycle. That bit is not captured, the partial word is dropped, and the pulse counts as the first pulse of a new lock attempt.
- R10: A write strobe while `fifo_full` is 1 sets `overflow` in the next cycle, and the strobe still happens. Only reset clears `overflow`.
- R11: Before sync, a second pulse at a non-expected position restarts the lock attempt with that pulse as the new first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data | input | 1 | Serial receive data |
| frm_pulse | input | 1 | Frame pulse, high for one bit clock |
| cfg_offset | input | LEN_W | Bit clocks from pulse to frame start |
| cfg_frame_len | input | LEN_W | Frame length in bit clocks, at least 2 |
| cfg_msb_first | input | 1 | Word packing order select |
| fifo_full | input | 1 | Downstream FIFO full indication |
| fifo_wr | output | 1 | One-cycle write strobe |
| fifo_wdata | output | WORD_W | Completed word |
| in_sync | output | 1 | Frame lock status |
| overflow | output | 1 | Sticky write-while-full flag |

## Verification
The bench builds the block with a 32-bit word, an 8-bit length field and both packing orders enabled. The 8-bit length field keeps frames between 33 and 200 bits, so many lock, loss and relock sequences fit into a short run. Because frames are longer than a word, word boundaries fall at shifting places inside the frame. Every nonzero offset in the range can also be reached, which exercises the late-start path next to the offset-zero path.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

   typedef enum logic [1:0] {
      SYNC_HUNT  = 2'd0,
      SYNC_FIRST = 2'd1,
      SYNC_LOCK  = 2'd2
   } sync_state_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rxfs_bit_counter.sv
module rxfs_bit_counter #(
   parameter int unsigned LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_pulse,
   input  logic [LEN_W-1:0] cfg_frame_len,
   output logic [LEN_W-1:0] bit_pos,
   output logic             on_boundary
);

   logic [LEN_W-1:0] next_pos_q;
   logic [LEN_W-1:0] last_pos;

   assign last_pos    = cfg_frame_len - 1'b1;
   assign bit_pos     = frm_pulse ? '0 : next_pos_q;
   assign on_boundary = (next_pos_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_pos_q <= '0;
      end else if (bit_pos >= last_pos) begin
         next_pos_q <= '0;
      end else begin
         next_pos_q <= bit_pos + 1'b1;
      end
   end

   AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cfg_frame_len) |-> next_pos_q < cfg_frame_len); // R2

endmodule

// File: rtl/rxfs_sync_fsm.sv
module rxfs_sync_fsm
   import rxfs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frm_pulse,
   input  logic        on_boundary,
   output sync_state_t state_q,
   output logic        sync_now,
   output logic        sync_lost,
   output logic        in_sync
);

   sync_state_t state_d;

   always_comb begin
      state_d   = state_q;
      sync_now  = 1'b0;
      sync_lost = 1'b0;
      unique case (state_q)
         SYNC_HUNT: begin
            if (frm_pulse) state_d = SYNC_FIRST;
         end
         SYNC_FIRST: begin
            if (frm_pulse && on_boundary) begin
               state_d  = SYNC_LOCK;
               sync_now = 1'b1;
            end
         end
         SYNC_LOCK: begin
            if (frm_pulse && !on_boundary) begin
               state_d   = SYNC_FIRST;
               sync_lost = 1'b1;
            end
         end
         default: state_d = SYNC_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SYNC_HUNT;
      else        state_q <= state_d;
   end

   assign in_sync = (state_q == SYNC_LOCK);

   AST_SYNC_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> $past(frm_pulse)); // R2

   AST_LOSS_ON_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && frm_pulse && !on_boundary) |=> !in_sync); // R9

   AST_NO_SINGLE_PULSE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SYNC_HUNT) |=> !in_sync); // R2

endmodule

// File: rtl/rxfs_word_packer.sv
module rxfs_word_packer
   import rxfs_pkg::*;
#(
   parameter int unsigned WORD_W       = 32,
   parameter bit          MSB_FIRST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   input  logic              msb_first,
   input  logic              capture_ok,
   input  logic              at_start,
   input  logic              flush,
   input  logic              fifo_full,
   output logic              wr_en,
   output logic [WORD_W-1:0] wr_data,
   output logic              overflow
);

   localparam int unsigned CNT_W    = cnt_width(WORD_W);
   localparam int unsigned LAST_IDX = WORD_W - 1;

   logic              cap_q;
   logic [CNT_W-1:0]  fill_q;
   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] shreg_d;
   logic              take;
   logic              word_done;
   logic              wr_en_q;
   logic [WORD_W-1:0] wr_data_q;
   logic              ovf_q;

   assign take      = capture_ok && (cap_q || at_start);
   assign word_done = take && (fill_q == CNT_W'(LAST_IDX));

   generate
      if (MSB_FIRST_EN) begin : g_both_orders
         always_comb begin
            if (msb_first) shreg_d = {shreg_q[WORD_W-2:0], bit_in};
            else           shreg_d = {bit_in, shreg_q[WORD_W-1:1]};
         end
      end else begin : g_lsb_only
         logic unused_sel;
         assign unused_sel = msb_first;
         assign shreg_d    = {bit_in, shreg_q[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q   <= 1'b0;
         fill_q  <= '0;
         shreg_q <= '0;
      end else if (flush) begin
         cap_q  <= 1'b0;
         fill_q <= '0;
      end else if (take) begin
         cap_q   <= 1'b1;
         shreg_q <= shreg_d;
         fill_q  <= word_done ? '0 : fill_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en_q   <= 1'b0;
         wr_data_q <= '0;
         ovf_q     <= 1'b0;
      end else begin
         wr_en_q <= word_done && !flush;
         if (word_done) wr_data_q <= shreg_d;
         ovf_q <= ovf_q | (wr_en_q & fifo_full);
      end
   end

   assign wr_en    = wr_en_q;
   assign wr_data  = wr_data_q;
   assign overflow = ovf_q;

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R6

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R10

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fifo_full) |=> overflow); // R10

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !wr_en); // R9

endmodule

// File: rtl/rxfs_frame_sync.sv
module rxfs_frame_sync
   import rxfs_pkg::*;
#(
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned LEN_W        = 10,
   parameter bit          MSB_FIRST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_data,
   input  logic              frm_pulse,
   input  logic [LEN_W-1:0]  cfg_offset,
   input  logic [LEN_W-1:0]  cfg_frame_len,
   input  logic              cfg_msb_first,
   input  logic              fifo_full,
   output logic              fifo_wr,
   output logic [WORD_W-1:0] fifo_wdata,
   output logic              in_sync,
   output logic              overflow
);

   generate
      if (WORD_W < 4) begin : g_bad_word
         $error("rxfs_frame_sync: WORD_W must be at least 4");
      end
      if (LEN_W < 2 || LEN_W > 24) begin : g_bad_len
         $error("rxfs_frame_sync: LEN_W must lie in 2..24");
      end
   endgenerate

   logic [LEN_W-1:0] bit_pos;
   logic             on_boundary;
   sync_state_t      state_q;
   logic             sync_now;
   logic             sync_lost;
   logic             locked_now;

   rxfs_bit_counter #(.LEN_W(LEN_W)) u_pos (
      .clk           (clk),
      .rst_n         (rst_n),
      .frm_pulse     (frm_pulse),
      .cfg_frame_len (cfg_frame_len),
      .bit_pos       (bit_pos),
      .on_boundary   (on_boundary)
   );

   rxfs_sync_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .frm_pulse   (frm_pulse),
      .on_boundary (on_boundary),
      .state_q     (state_q),
      .sync_now    (sync_now),
      .sync_lost   (sync_lost),
      .in_sync     (in_sync)
   );

   assign locked_now = ((state_q == SYNC_LOCK) && !sync_lost) || sync_now;

   rxfs_word_packer #(
      .WORD_W       (WORD_W),
      .MSB_FIRST_EN (MSB_FIRST_EN)
   ) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_in     (ser_data),
      .msb_first  (cfg_msb_first),
      .capture_ok (locked_now),
      .at_start   (bit_pos == cfg_offset),
      .flush      (sync_lost),
      .fifo_full  (fifo_full),
      .wr_en      (fifo_wr),
      .wr_data    (fifo_wdata),
      .overflow   (overflow)
   );

   AST_NO_WR_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> in_sync); // R3

   AST_OFFSET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_offset < cfg_frame_len); // R5

endmodule

// File: tb/rxfs_frame_sync_bench.sv
module rxfs_frame_sync_bench;

   localparam int W  = 32;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ser_data, frm_pulse, cfg_msb_first, fifo_full;
   logic [LW-1:0] cfg_offset, cfg_frame_len;
   logic          fifo_wr, in_sync, overflow;
   logic [W-1:0]  fifo_wdata;

   always #4 clk = ~clk;

   rxfs_frame_sync #(.WORD_W(W), .LEN_W(LW), .MSB_FIRST_EN(1'b1)) u_rxfs_frame_sync (
      .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .frm_pulse(frm_pulse),
      .cfg_offset(cfg_offset), .cfg_frame_len(cfg_frame_len),
      .cfg_msb_first(cfg_msb_first), .fifo_full(fifo_full),
      .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
      .in_sync(in_sync), .overflow(overflow)
   );

   int n_chk = 0, n_err = 0;
   int ncyc, sync_call, first_wr, g_phase;
   int m_st, m_pos, m_cap, m_nb;
   int c_len, c_off, c_msb;
   logic [W-1:0] m_word, exp_word, first_word;
   logic exp_wr, exp_sync, exp_ovf;

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, expv);
      end
   endtask

   // reference: expected sync/capture behaviour from the requirements
   task automatic model_bit(input logic d, input logic p);
      int idx = p ? 0 : m_pos;
      bit stray = 0;
      if (p) begin
         if (m_st == 0) m_st = 1;
         else if (m_st == 1) begin
            if (m_pos == 0) begin
               m_st = 2;
               if (sync_call < 0) sync_call = ncyc;
            end
         end else if (m_pos != 0) begin
            m_st = 1; stray = 1; m_cap = 0; m_nb = 0;
         end
      end
      if (m_st == 2 && !stray) begin
         if (!m_cap && idx == c_off) m_cap = 1;
         if (m_cap) begin
            if (c_msb != 0) m_word[W-1-m_nb] = d;
            else            m_word[m_nb] = d;
            m_nb++;
            if (m_nb == W) begin
               exp_wr = 1'b1; exp_word = m_word; m_nb = 0;
            end
         end
      end
      m_pos    = (idx + 1 == c_len) ? 0 : idx + 1;
      exp_sync = (m_st == 2);
   endtask

   task automatic step(input logic d, input logic p, input logic f);
      @(negedge clk);
      chk(fifo_wr === exp_wr, "R6 write strobe", W'(fifo_wr), W'(exp_wr));
      if (exp_wr) chk(fifo_wdata === exp_word, "R7 R8 word content", fifo_wdata, exp_word);
      if (fifo_wr && sync_call < 0) chk(1'b0, "R3 write before sync", W'(1), W'(0));
      if (fifo_wr && first_wr < 0) begin
         first_wr = ncyc; first_word = fifo_wdata;
      end
      chk(in_sync === exp_sync, "R2 R9 sync flag", W'(in_sync), W'(exp_sync));
      chk(overflow === exp_ovf, "R10 overflow", W'(overflow), W'(exp_ovf));
      fifo_full = f;
      if (exp_wr && f) exp_ovf = 1'b1;
      exp_wr = 1'b0;
      model_bit(d, p);
      ser_data = d; frm_pulse = p;
      ncyc++;
   endtask

   task automatic do_reset(input int len, input int off, input int msb);
      @(negedge clk);
      rst_n = 1'b0; ser_data = 0; frm_pulse = 0; fifo_full = 0;
      cfg_frame_len = LW'(len); cfg_offset = LW'(off); cfg_msb_first = msb[0];
      c_len = len; c_off = off; c_msb = msb;
      repeat (3) @(negedge clk);
      chk(in_sync === 1'b0 && fifo_wr === 1'b0 && overflow === 1'b0, "R1 reset state",
          W'({in_sync, fifo_wr, overflow}), W'(0));
      rst_n = 1'b1;
      m_st = 0; m_pos = 0; m_cap = 0; m_nb = 0; m_word = '0;
      exp_wr = 0; exp_sync = 0; exp_ovf = 0;
      sync_call = -1; first_wr = -1; ncyc = 0; g_phase = 0;
   endtask

   task automatic run(input int nbits, input int drop_pct, input int stray_pm, input bit pat, input logic f);
      for (int i = 0; i < nbits; i++) begin
         logic p, d;
         p = (g_phase == 0);
         if (p && drop_pct > 0 && $urandom_range(99) < drop_pct) p = 0;
         if (!p && g_phase != 0 && stray_pm > 0 && $urandom_range(999) < stray_pm) begin
            p = 1; g_phase = 0;
         end
         d = pat ? (g_phase == c_off) : 1'($urandom_range(1));
         step(d, p, f);
         g_phase = (g_phase + 1 == c_len) ? 0 : g_phase + 1;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'h1D5E_ED01));
      rst_n = 1'b0;

      // offset zero, order 0: first word starts on sync pulse bit
      do_reset(40, 0, 0);
      run(200, 0, 0, 1'b1, 1'b0);
      chk(sync_call == 40, "R2 sync on second pulse", W'(sync_call), W'(40));
      chk(first_wr - sync_call == 32, "R4 first write delay", W'(first_wr - sync_call), W'(32));
      chk(first_word == 32'h0000_0001, "R7 first bit at bit 0", first_word, 32'h1);

      // nonzero offset, order 1
      do_reset(40, 5, 1);
      run(200, 0, 0, 1'b1, 1'b0);
      chk(first_wr - sync_call == 37, "R5 first write delay", W'(first_wr - sync_call), W'(37));
      chk(first_word == 32'h8000_0000, "R8 first bit at bit 31", first_word, 32'h8000_0000);

      // stray pulse while locked
      do_reset(48, 3, 0);
      run(300, 0, 0, 1'b0, 1'b0);
      if (g_phase == 0) run(1, 0, 0, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      g_phase = 1;
      @(posedge clk); #1;
      chk(in_sync === 1'b0, "R9 lock dropped by stray pulse", W'(in_sync), W'(0));
      run(200, 0, 0, 1'b0, 1'b0);
      chk(in_sync === 1'b1, "R9 relock after stray", W'(in_sync), W'(1));

      // gapped pulses keep lock
      do_reset(36, 0, 0);
      run(120, 0, 0, 1'b0, 1'b0);
      run(80, 100, 0, 1'b0, 1'b0);
      chk(in_sync === 1'b1, "R2 gapped pulses keep lock", W'(in_sync), W'(1));
      run(60, 0, 0, 1'b0, 1'b0);

      // overflow sticky
      do_reset(40, 2, 0);
      run(150, 0, 0, 1'b0, 1'b1);
      chk(overflow === 1'b1, "R10 overflow set", W'(overflow), W'(1));
      run(100, 0, 0, 1'b0, 1'b0);
      chk(overflow === 1'b1, "R10 overflow sticky", W'(overflow), W'(1));

      // misplaced second pulse before sync restarts the attempt
      do_reset(40, 0, 0);
      step(1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0);
      g_phase = 0;
      run(150, 0, 0, 1'b0, 1'b0);
      chk(sync_call == 51, "R11 restart on misplaced pulse", W'(sync_call), W'(51));

      // random frames
      for (int s = 0; s < 8; s++) begin
         int len = $urandom_range(200, 33);
         do_reset(len, $urandom_range(len - 1, 0), $urandom_range(1));
         run(3000, 8, 3, 1'b0, (s == 5) ? 1'b1 : 1'b0);
      end

      step(1'b0, 1'b0, 1'b0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule